// File: doc/BRIEF.md
# Wave32 Source Operand Selector

This block is the operand-fetch multiplexer of a 32-lane SIMD core. An instruction source field arrives as a 9-bit code, together with the lane being served and a format select. The block turns these into one 64-bit operand value. The value can come from several places:

- the scalar register file;
- the per-lane vector register file;
- the scalar condition flag;
- the instruction literal;
- a built-in table of inline constants, whose bit patterns depend on the format (16-bit, 32-bit or 64-bit).

The block is purely combinational. It drives register indices out to two scalar read ports and two vector read ports, and receives their data back in the same cycle. The second port of each pair serves the upper dword when a 64-bit operand is built from a register pair.

Format select encoding: 2'b00 selects 32-bit, 2'b01 selects 16-bit, 2'b10 selects 64-bit, and 2'b11 behaves as 32-bit.

Top module: `src_operand_select`

## Requirements
- R1: In 32-bit mode, a code from 0 to 127 other than 124 returns scalar register `code` in bits 31:0, with bits 63:32 zero.
- R2: In 32-bit mode, a code from 256 to 511 returns vector register (code − 256) of the lane on `lane_sel` in bits 31:0, with bits 63:32 zero.
- R3: Integer inline codes behave as follows, each value sign-extended to the active width (16, 32 or 64 bits) with all output bits above that width zero:
  - codes 128 to 192 give the integers 0 to 64;
  - codes 193 to 208 give −1 to −16.
- R4: Codes 240 to 247 give +0.5, −0.5, +1.0, −1.0, +2.0, −2.0, +4.0, −4.0 in that order, as IEEE half, single or double according to the format.
- R5: Code 248 gives 1/(2π) in the following patterns, zero-extended to 64 bits:
  - 16-bit: 16'h3118;
  - 32-bit: 32'h3E22F983;
  - 64-bit: 64'h3FC45F306DC9C883.
- R6: Code 255 returns the literal as follows:
  - in 64-bit mode, all 64 bits unchanged;
  - otherwise, its low 32 bits with bits 63:32 zero.
- R7: The inline codes 209 to 239, 249 to 252 and 254 return zero in every format.
- R8: The condition flag and the null code behave as follows:
  - code 124 (null) returns zero in every format;
  - code 253 returns the condition flag zero-extended in 16-bit and 32-bit modes;
  - code 253 returns zero in 64-bit mode, because it falls in the inline range there.
- R9: In 64-bit mode, a register code returns the low dword from the code itself. The upper dword is set as follows:
  - scalar codes below 106: taken from register code+1;
  - vector codes 256 to 510: taken from register code+1 of the same lane;
  - all other register codes, including 106 to 127 and 511: zero.
- R10: Format 2'b11 behaves exactly as 32-bit. The 16-bit format changes only the inline constants: register codes 0 to 127 and 256 to 511 return the same full 32-bit word as in 32-bit mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_code | input | 9 | Source operand code |
| lane_sel | input | 5 | Lane whose vector register is read |
| fmt | input | 2 | Format: 00 32-bit, 01 16-bit, 10 64-bit, 11 32-bit |
| scc_flag | input | 1 | Scalar condition flag |
| literal | input | 64 | Instruction literal register |
| sreg_lo_idx | output | 7 | Scalar read index, low dword |
| sreg_lo_val | input | 32 | Scalar read data, low dword |
| sreg_hi_idx | output | 7 | Scalar read index, upper dword |
| sreg_hi_val | input | 32 | Scalar read data, upper dword |
| vreg_lane | output | 5 | Lane for both vector read ports |
| vreg_lo_idx | output | 8 | Vector read index, low dword |
| vreg_lo_val | input | 32 | Vector read data, low dword |
| vreg_hi_idx | output | 8 | Vector read index, upper dword |
| vreg_hi_val | input | 32 | Vector read data, upper dword |
| operand | output | 64 | Selected operand value |

## Verification
The hardest cases to reach are the pair-boundary codes in 64-bit mode:

- scalar code 105 against 106;
- vector code 510 against 511;
- the condition-flag code, which silently becomes an inline zero in 64-bit mode.

Each of these shows a difference only when the neighbouring register holds a distinct nonzero value and the flag is set. The stimulus therefore fills both register files with lane- and index-dependent patterns that change from cycle to cycle. It sweeps every code in every format with the flag held high in the 16-bit, 64-bit and 2'b11 formats, and then follows with random cycles that reseed the patterns, the literal and the flag.

// File: rtl/src_operand_select.sv
module src_operand_select #(
  parameter int CODE_W = 9,
  parameter int LANE_W = 5,
  parameter int SREG_W = 7,
  parameter int DW     = 32
) (
  input  logic [CODE_W-1:0]   src_code,
  input  logic [LANE_W-1:0]   lane_sel,
  input  logic [1:0]          fmt,
  input  logic                scc_flag,
  input  logic [2*DW-1:0]     literal,
  output logic [SREG_W-1:0]   sreg_lo_idx,
  input  logic [DW-1:0]       sreg_lo_val,
  output logic [SREG_W-1:0]   sreg_hi_idx,
  input  logic [DW-1:0]       sreg_hi_val,
  output logic [LANE_W-1:0]   vreg_lane,
  output logic [CODE_W-2:0]   vreg_lo_idx,
  input  logic [DW-1:0]       vreg_lo_val,
  output logic [CODE_W-2:0]   vreg_hi_idx,
  input  logic [DW-1:0]       vreg_hi_val,
  output logic [2*DW-1:0]     operand
);
  localparam int QW = 2 * DW;
  localparam int VW = CODE_W - 1;
  localparam logic [CODE_W-1:0] C_PAIR_LIM = CODE_W'(106);
  localparam logic [CODE_W-1:0] C_NULL     = CODE_W'(124);
  localparam logic [CODE_W-1:0] C_INL_LO   = CODE_W'(128);
  localparam logic [CODE_W-1:0] C_POS_MAX  = CODE_W'(192);
  localparam logic [CODE_W-1:0] C_NEG_MAX  = CODE_W'(208);
  localparam logic [CODE_W-1:0] C_FLT_LO   = CODE_W'(240);
  localparam logic [CODE_W-1:0] C_FLT_HI   = CODE_W'(247);
  localparam logic [CODE_W-1:0] C_INV2PI   = CODE_W'(248);
  localparam logic [CODE_W-1:0] C_SCC      = CODE_W'(253);
  localparam logic [CODE_W-1:0] C_LIT      = CODE_W'(255);
  localparam logic [15:0] INV2PI_H = 16'h3118;
  localparam logic [31:0] INV2PI_S = 32'h3E22F983;
  localparam logic [63:0] INV2PI_D = 64'h3FC45F306DC9C883;

  logic wide, half, is_vreg, is_sreg, pair_ok;
  logic [1:0] fidx;
  logic [QW-1:0] width_mask, int_k, flt_k, inl_k;

  assign wide    = (fmt == 2'b10);
  assign half    = (fmt == 2'b01);
  assign is_vreg = src_code[CODE_W-1];
  assign is_sreg = ~src_code[CODE_W-1] & ~src_code[CODE_W-2];

  assign sreg_lo_idx = src_code[SREG_W-1:0];
  assign sreg_hi_idx = src_code[SREG_W-1:0] + SREG_W'(1);
  assign vreg_lane   = lane_sel;
  assign vreg_lo_idx = src_code[VW-1:0];
  assign vreg_hi_idx = src_code[VW-1:0] + VW'(1);

  assign pair_ok = wide & ((is_sreg & (src_code < C_PAIR_LIM)) |
                           (is_vreg & ~(&src_code[VW-1:0])));

  assign width_mask = wide ? {QW{1'b1}} : half ? QW'({(DW/2){1'b1}}) : QW'({DW{1'b1}});
  assign fidx = src_code[2:1];

  always_comb begin
    if (src_code <= C_POS_MAX) int_k = QW'(src_code - C_INL_LO);
    else                       int_k = ~QW'(src_code - C_POS_MAX) + QW'(1);
  end

  always_comb begin
    if (wide)      flt_k = {src_code[0], 11'(11'd1022 + 11'(fidx)), 52'd0};
    else if (half) flt_k = QW'({src_code[0], 5'(5'd14 + 5'(fidx)), 10'd0});
    else           flt_k = QW'({src_code[0], 8'(8'd126 + 8'(fidx)), 23'd0});
  end

  always_comb begin
    inl_k = '0;
    if (src_code <= C_NEG_MAX)
      inl_k = int_k & width_mask;
    else if (src_code >= C_FLT_LO && src_code <= C_FLT_HI)
      inl_k = flt_k;
    else if (src_code == C_INV2PI)
      inl_k = wide ? INV2PI_D : half ? QW'(INV2PI_H) : QW'(INV2PI_S);
  end

  always_comb begin
    if (is_sreg)
      operand = (src_code == C_NULL) ? '0 :
                {pair_ok ? sreg_hi_val : {DW{1'b0}}, sreg_lo_val};
    else if (is_vreg)
      operand = {pair_ok ? vreg_hi_val : {DW{1'b0}}, vreg_lo_val};
    else if (src_code == C_LIT)
      operand = wide ? literal : {{DW{1'b0}}, literal[DW-1:0]};
    else if (src_code == C_SCC && !wide)
      operand = QW'(scc_flag);
    else
      operand = inl_k;
  end

  always_comb begin
    if (src_code == C_NULL)
      p_null_zero_r8: assert (operand == '0);
    if (src_code == C_SCC && !wide)
      p_scc_extend_r8: assert (operand == QW'(scc_flag));
    if (src_code == C_LIT && wide)
      p_literal_whole_r6: assert (operand == literal);
    if (!wide)
      p_narrow_upper_r10: assert (operand[QW-1:DW] == '0);
    if (half && src_code >= C_INL_LO && src_code < C_LIT && src_code != C_SCC)
      p_half_inline_r3: assert (operand[QW-1:16] == '0);
    if (wide && is_vreg && (&src_code[VW-1:0]))
      p_last_vreg_pair_r9: assert (operand[QW-1:DW] == '0);
  end
endmodule

// File: tb/src_operand_select_bench.sv
`timescale 1ns/1ps
module src_operand_select_bench;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n;
  logic [8:0]  src_code;
  logic [4:0]  lane_sel;
  logic [1:0]  fmt;
  logic        scc_flag;
  logic [63:0] literal;
  logic [6:0]  sreg_lo_idx, sreg_hi_idx;
  logic [31:0] sreg_lo_val, sreg_hi_val, vreg_lo_val, vreg_hi_val;
  logic [4:0]  vreg_lane;
  logic [7:0]  vreg_lo_idx, vreg_hi_idx;
  logic [63:0] operand;
  logic [31:0] seed;
  int total = 0, bad = 0;
  bit finished = 0;

  src_operand_select u_src_operand_select (
    .src_code(src_code), .lane_sel(lane_sel), .fmt(fmt), .scc_flag(scc_flag),
    .literal(literal),
    .sreg_lo_idx(sreg_lo_idx), .sreg_lo_val(sreg_lo_val),
    .sreg_hi_idx(sreg_hi_idx), .sreg_hi_val(sreg_hi_val),
    .vreg_lane(vreg_lane),
    .vreg_lo_idx(vreg_lo_idx), .vreg_lo_val(vreg_lo_val),
    .vreg_hi_idx(vreg_hi_idx), .vreg_hi_val(vreg_hi_val),
    .operand(operand));

  function automatic logic [31:0] sval(input int i);
    return 32'hA5000000 ^ (32'(i) * 32'h01010101) ^ seed;
  endfunction

  function automatic logic [31:0] vval(input int ln, input int r);
    return ({19'd0, 5'(ln), 8'(r)} * 32'h9E3779B1) ^ {seed[15:0], seed[31:16]};
  endfunction

  always_comb begin
    sreg_lo_val = sval(int'(sreg_lo_idx));
    sreg_hi_val = sval(int'(sreg_hi_idx));
    vreg_lo_val = vval(int'(vreg_lane), int'(vreg_lo_idx));
    vreg_hi_val = vval(int'(vreg_lane), int'(vreg_hi_idx));
  end

  function automatic logic [63:0] fenc(input real r, input int w);
    logic [63:0] b;
    logic [31:0] t;
    int e;
    b = $realtobits(r);
    e = int'(b[62:52]) - 1023;
    if (w == 64) return b;
    if (w == 32) begin
      t = {1'b0, 8'(e + 127), b[51:29]} + {31'd0, b[28]};
      t[31] = b[63];
      return {32'd0, t};
    end
    t = {17'd0, 5'(e + 15), b[51:42]} + {31'd0, b[41]};
    t[15] = b[63];
    return {48'd0, t[15:0]};
  endfunction

  function automatic logic [63:0] model(input int code, input int ln, input int f,
                                       input logic s, input logic [63:0] lit,
                                       output string tag);
    bit wide, half;
    int w, k;
    logic [63:0] v, m;
    wide = (f == 2);
    half = (f == 1);
    w = wide ? 64 : half ? 16 : 32;
    m = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
    v = '0;
    k = code - 128;
    if (code == 124) begin tag = "R8"; v = '0; end
    else if (code < 128) begin
      tag = wide ? "R9" : "R1";
      v = {(wide && code < 106) ? sval(code + 1) : 32'd0, sval(code)};
    end else if (code >= 256) begin
      tag = wide ? "R9" : "R2";
      v = {(wide && code < 511) ? vval(ln, code - 255) : 32'd0, vval(ln, code - 256)};
    end else if (code == 255) begin
      tag = "R6"; v = wide ? lit : {32'd0, lit[31:0]};
    end else if (code == 253) begin
      tag = "R8"; v = wide ? 64'd0 : {63'd0, s};
    end else if (k <= 64) begin
      tag = "R3"; v = 64'(k) & m;
    end else if (k <= 80) begin
      tag = "R3"; v = (64'd0 - 64'(k - 64)) & m;
    end else if (code >= 240 && code <= 247) begin
      tag = "R4";
      v = fenc(((code % 2) ? -0.5 : 0.5) * real'(1 << ((code - 240) / 2)), w);
    end else if (code == 248) begin
      tag = "R5"; v = fenc(1.0 / (2.0 * 3.141592653589793), w);
    end else begin
      tag = "R7"; v = '0;
    end
    if (f == 3 || (half && (code < 128 || code >= 256)) && code != 124) tag = "R10";
    return v;
  endfunction

  task automatic drive(input int code, input int ln, input int f, input logic s,
                       input logic [63:0] lit, input logic [31:0] sd);
    @(posedge clk);
    #1;
    src_code = 9'(code); lane_sel = 5'(ln); fmt = 2'(f);
    scc_flag = s; literal = lit; seed = sd;
  endtask

  task automatic check_now();
    string tag;
    logic [63:0] exp;
    @(negedge clk);
    exp = model(int'(src_code), int'(lane_sel), int'(fmt), scc_flag, literal, tag);
    total++;
    if (operand !== exp) begin
      bad++;
      $display("FAIL %s code=%0d fmt=%0d lane=%0d got=%h exp=%h",
               tag, src_code, fmt, lane_sel, operand, exp);
    end
  endtask

  initial begin
    rst_n = 1'b0;
    src_code = 9'd124; lane_sel = '0; fmt = 2'b00; scc_flag = 1'b1;
    literal = 64'h0123456789ABCDEF; seed = 32'h1;
    for (int i = 0; i < 3; i++) check_now();   // reset state: null code reads zero (R8)
    rst_n = 1'b1;
    // full sweep: every code in every format (R1..R10)
    for (int f = 0; f < 4; f++)
      for (int c = 0; c < 512; c++) begin
        drive(c, (c * 7 + f) % 32, f, (f != 0), 64'hFEDCBA98_7654321F ^ 64'(c),
              32'h3C00_0000 + 32'(c * 13 + f));
        check_now();
      end
    // pair boundaries in 64-bit mode (R9)
    drive(105, 3, 2, 1'b1, 64'h0, 32'h77); check_now();
    drive(106, 3, 2, 1'b1, 64'h0, 32'h77); check_now();
    drive(510, 31, 2, 1'b1, 64'h0, 32'h99); check_now();
    drive(511, 31, 2, 1'b1, 64'h0, 32'h99); check_now();
    // random traffic
    for (int n = 0; n < 3000; n++) begin
      drive(int'($urandom % 512), int'($urandom % 32), int'($urandom % 4),
            1'($urandom), {$urandom, $urandom}, $urandom);
      check_now();
    end
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(100000 * 5.0);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not complete got=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule